// File: doc/BRIEF.md
# Infrared Carrier and Timer Prescaler Generator

This block produces the modulation carrier for an infrared remote-control transmitter, and a periodic timer tick, from one oscillator. It runs on a clock at twice the oscillator frequency (2·fOSC), so every divide count is a whole number of clock cycles and even the fastest carrier, which runs at the oscillator rate, has an exact 50% duty cycle. An 8-bit control register, written over a simple parallel bus, selects one of four carrier shapes. It can also disable the carrier, which leaves a steady high level, and it can halve every carrier frequency and the timer tick rate together.

The carrier output is registered and gated by a transmit-enable input. While transmit-enable is low the output is low. While it is high the output carries the carrier, or the steady high level when the carrier is disabled. Any register write restarts the carrier at the start of a high phase, so a change of setting never produces a runt pulse. The timer tick is a one-cycle pulse from a free-running prescaler. The prescaler restarts when the halving bit changes value. Two register bits are held as the upper data-pointer bits and are only driven out.

Top module: `ir_carrier_gen`

## Requirements
- R1: After reset, rd_data is 8'h03, carrier_out is 0, timer_tick is 0 and dp_hi is 0.
- R2: rd_data[7:6] always read 0. Write data in bits 7:6 is discarded. Bits 5:0 of a write appear on rd_data in the cycle after the write.
- R3: With rd_data[3]=0, tx_en=1 and rd_data[2]=0, the carrier is periodic. The sel field (rd_data[1:0]) sets period and high time in clock cycles: 00 gives period 2 and high 1, 01 gives 16 and 8, 10 gives 24 and 12, 11 gives 24 and 8.
- R4: When rd_data[2]=1 and tx_en was 1 at the previous clock edge, carrier_out is 1, whatever the sel field holds.
- R5: When rd_data[3]=1, every carrier period and high time in R3 is doubled (4/2, 32/16, 48/24, 48/16), so the duty ratio is unchanged.
- R6: timer_tick is a single-cycle pulse. It fires once every 16 cycles when rd_data[3]=0 and once every 32 cycles when rd_data[3]=1.
- R7: dp_hi equals rd_data[5:4].
- R8: Every register write restarts the carrier counter. With tx_en=1, carrier_out is high for a full high phase starting in the cycle after the write.
- R9: When tx_en was 0 at the previous clock edge, carrier_out is 0.
- R10: A write that changes bit 3 clears the prescaler. The next tick comes a full prescaler period after the write, with no tick in the cycle after the write.
- R11: In the 1/3-duty setting (sel 11), the high time comes first in each period, followed by twice that time low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock at twice the oscillator frequency |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Control register write strobe |
| wr_data | input | 8 | Control register write data |
| tx_en | input | 1 | Transmit enable that gates the carrier |
| rd_data | output | 8 | Control register contents |
| dp_hi | output | 2 | Stored upper data-pointer bits |
| carrier_out | output | 1 | Registered, gated carrier waveform |
| timer_tick | output | 1 | One-cycle timer prescaler pulse |

## Verification
The bench keeps a cycle-level reference model and drives it with random writes and random tx_en changes, plus directed cases. Writes land at arbitrary counter phases to catch a design that keeps counting after a write: such a design would emit a short first pulse. Halving toggles are aimed at the prescaler. A prescaler that is not cleared would tick early, or would overrun the shorter limit after a 1-to-0 change. Sel 11 confirms that the high third comes first; a design with swapped phases would start low after a restart. Writes of all-ones check that bits 7:6 stay zero, and that a disabled carrier gives a steady high rather than a low.

// File: rtl/ir_carrier_pkg.sv
package ir_carrier_pkg;

  localparam int CTRL_W = 8;
  localparam logic [CTRL_W-1:0] CTRL_RST  = 8'h03;
  localparam logic [CTRL_W-1:0] CTRL_MASK = 8'h3F;

  typedef struct packed {
    logic [1:0] rsvd;
    logic [1:0] dp;
    logic       halve;
    logic       off;
    logic [1:0] sel;
  } ir_ctrl_t;

  // Carrier period in clock cycles (clock = 2 x oscillator)
  function automatic int unsigned car_period(input logic [1:0] sel, input logic halve);
    int unsigned base;
    case (sel)
      2'b00:   base = 2;
      2'b01:   base = 16;
      default: base = 24;
    endcase
    return halve ? base * 2 : base;
  endfunction

  // High time of the carrier in clock cycles, placed at the start of a period
  function automatic int unsigned car_high(input logic [1:0] sel, input logic halve);
    int unsigned base;
    case (sel)
      2'b00:   base = 1;
      2'b01:   base = 8;
      2'b10:   base = 12;
      default: base = 8;
    endcase
    return halve ? base * 2 : base;
  endfunction

endpackage

// File: rtl/ir_ctrl_reg.sv
module ir_ctrl_reg
  import ir_carrier_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [CTRL_W-1:0] wr_data,
  output ir_ctrl_t          ctrl_q,
  output ir_ctrl_t          ctrl_d,
  output logic              restart,
  output logic              halve_flip
);

  always_comb begin
    ctrl_d     = wr_en ? ir_ctrl_t'(wr_data & CTRL_MASK) : ctrl_q;
    restart    = wr_en;
    halve_flip = wr_en && (wr_data[3] != ctrl_q.halve);
  end

  always_ff @(posedge clk) begin
    if (rst) ctrl_q <= ir_ctrl_t'(CTRL_RST);
    else     ctrl_q <= ctrl_d;
  end

  p_rsvd_zero_r2: assert property (@(posedge clk) disable iff (rst)
    $past(wr_en) |-> (ctrl_q.rsvd == 2'b00));

endmodule

// File: rtl/ir_carrier_div.sv
module ir_carrier_div
  import ir_carrier_pkg::*;
#(
  parameter int CNT_W = 6
) (
  input  logic       clk,
  input  logic       rst,
  input  logic [1:0] sel_q,
  input  logic       halve_q,
  input  logic [1:0] sel_d,
  input  logic       halve_d,
  input  logic       off_d,
  input  logic       restart,
  input  logic       tx_en,
  output logic       carrier_out
);

  logic [CNT_W-1:0] cnt_q, cnt_d, per_m1, high_d;
  logic             wave_d;

  always_comb begin
    per_m1 = CNT_W'(car_period(sel_q, halve_q) - 1);
    high_d = CNT_W'(car_high(sel_d, halve_d));
    if (restart)              cnt_d = '0;
    else if (cnt_q == per_m1) cnt_d = '0;
    else                      cnt_d = cnt_q + 1'b1;
    wave_d = off_d | (cnt_d < high_d);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q       <= '0;
      carrier_out <= 1'b0;
    end else begin
      cnt_q       <= cnt_d;
      carrier_out <= tx_en & wave_d;
    end
  end

  p_cnt_bound_r3: assert property (@(posedge clk) disable iff (rst)
    cnt_q <= per_m1);

  p_restart_zero_r8: assert property (@(posedge clk) disable iff (rst)
    restart |=> (cnt_q == '0));

endmodule

// File: rtl/ir_prescaler.sv
module ir_prescaler #(
  parameter int TICK_DIV = 16,
  localparam int PRE_W   = $clog2(2 * TICK_DIV)
) (
  input  logic clk,
  input  logic rst,
  input  logic halve_q,
  input  logic clear,
  output logic tick
);

  logic [PRE_W-1:0] pre_q, pre_d, lim_m1;

  always_comb begin
    lim_m1 = halve_q ? PRE_W'(2 * TICK_DIV - 1) : PRE_W'(TICK_DIV - 1);
    if (clear)                pre_d = '0;
    else if (pre_q == lim_m1) pre_d = '0;
    else                      pre_d = pre_q + 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      pre_q <= '0;
      tick  <= 1'b0;
    end else begin
      pre_q <= pre_d;
      tick  <= !clear && (pre_q == lim_m1);
    end
  end

  p_tick_single_r6: assert property (@(posedge clk) disable iff (rst)
    tick |=> !tick);

  p_clear_quiet_r10: assert property (@(posedge clk) disable iff (rst)
    clear |=> !tick);

  p_pre_bound_r10: assert property (@(posedge clk) disable iff (rst)
    pre_q <= lim_m1);

endmodule

// File: rtl/ir_carrier_gen.sv
module ir_carrier_gen
  import ir_carrier_pkg::*;
#(
  parameter int CNT_W    = 6,
  parameter int TICK_DIV = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [CTRL_W-1:0] wr_data,
  input  logic              tx_en,
  output logic [CTRL_W-1:0] rd_data,
  output logic [1:0]        dp_hi,
  output logic              carrier_out,
  output logic              timer_tick
);

  ir_ctrl_t ctrl_q, ctrl_d;
  logic     restart, halve_flip;

  ir_ctrl_reg u_reg (
    .clk        (clk),
    .rst        (rst),
    .wr_en      (wr_en),
    .wr_data    (wr_data),
    .ctrl_q     (ctrl_q),
    .ctrl_d     (ctrl_d),
    .restart    (restart),
    .halve_flip (halve_flip)
  );

  ir_carrier_div #(.CNT_W(CNT_W)) u_div (
    .clk         (clk),
    .rst         (rst),
    .sel_q       (ctrl_q.sel),
    .halve_q     (ctrl_q.halve),
    .sel_d       (ctrl_d.sel),
    .halve_d     (ctrl_d.halve),
    .off_d       (ctrl_d.off),
    .restart     (restart),
    .tx_en       (tx_en),
    .carrier_out (carrier_out)
  );

  ir_prescaler #(.TICK_DIV(TICK_DIV)) u_pre (
    .clk     (clk),
    .rst     (rst),
    .halve_q (ctrl_q.halve),
    .clear   (halve_flip),
    .tick    (timer_tick)
  );

  assign rd_data = ctrl_q;
  assign dp_hi   = ctrl_q.dp;

  p_tx_low_r9: assert property (@(posedge clk) disable iff (rst)
    !$past(tx_en) |-> !carrier_out);

  p_restart_high_r8: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) && $past(wr_en) && $past(tx_en) |-> carrier_out);

  p_off_high_r4: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) && $past(tx_en) && rd_data[2] |-> carrier_out);

  p_dp_follow_r7: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) && $past(wr_en) |-> (dp_hi == $past(wr_data[5:4])));

endmodule

// File: tb/ir_carrier_gen_tb.sv
module ir_carrier_gen_tb;

  logic       clk = 1'b0;
  logic       rst, wr_en, tx_en;
  logic [7:0] wr_data;
  logic [7:0] rd_data;
  logic [1:0] dp_hi;
  logic       carrier_out, timer_tick;

  int checks = 0, fails = 0;
  bit done = 0;

  // reference model state
  logic [7:0] m_ctrl;
  int         m_cnt, m_pre, wr_age;
  logic       m_out, m_tick, m_clear;

  always #4 clk = ~clk;

  ir_carrier_gen u_dut (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_data(wr_data), .tx_en(tx_en),
    .rd_data(rd_data), .dp_hi(dp_hi), .carrier_out(carrier_out), .timer_tick(timer_tick)
  );

  function automatic int exp_period(input logic [7:0] c);
    int b;
    b = (c[1:0] == 2'b00) ? 2 : (c[1:0] == 2'b01) ? 16 : 24;
    return c[3] ? 2 * b : b;
  endfunction

  function automatic int exp_high(input logic [7:0] c);
    int b;
    case (c[1:0])
      2'b00: b = 1;
      2'b01: b = 8;
      2'b10: b = 12;
      default: b = 8;
    endcase
    return c[3] ? 2 * b : b;
  endfunction

  function automatic int tick_lim(input logic [7:0] c);
    return c[3] ? 32 : 16;
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  // one clock: model advances with the inputs held over the edge, outputs checked at the falling edge
  task automatic step();
    @(posedge clk);
    if (rst) begin
      m_ctrl = 8'h03; m_cnt = 0; m_pre = 0; m_out = 0; m_tick = 0; wr_age = 100; m_clear = 0;
    end else begin
      m_clear = wr_en && (wr_data[3] != m_ctrl[3]);
      m_tick  = !m_clear && (m_pre == tick_lim(m_ctrl) - 1);
      m_pre   = m_clear ? 0 : ((m_pre == tick_lim(m_ctrl) - 1) ? 0 : m_pre + 1);
      if (wr_en) m_cnt = 0;
      else       m_cnt = (m_cnt == exp_period(m_ctrl) - 1) ? 0 : m_cnt + 1;
      if (wr_en) begin m_ctrl = wr_data & 8'h3F; wr_age = 0; end
      else if (wr_age < 100) wr_age++;
      m_out = tx_en & (m_ctrl[2] | (m_cnt < exp_high(m_ctrl)));
    end
    @(negedge clk);
    if (!rst) begin
      string rq;
      if (!tx_en)                              rq = "R9";
      else if (m_ctrl[2])                      rq = "R4";
      else if (wr_age < exp_period(m_ctrl))    rq = "R8";
      else if (m_ctrl[3])                      rq = "R5";
      else if (m_ctrl[1:0] == 2'b11)           rq = "R11";
      else                                     rq = "R3";
      chk(rq, 32'(carrier_out), 32'(m_out));
      chk(m_clear ? "R10" : "R6", 32'(timer_tick), 32'(m_tick));
      chk("R2", 32'(rd_data), 32'(m_ctrl));
      chk("R7", 32'(dp_hi), 32'(m_ctrl[5:4]));
    end
  endtask

  task automatic write(input logic [7:0] d);
    wr_en = 1'b1; wr_data = d;
    step();
    wr_en = 1'b0;
  endtask

  task automatic run(input int n);
    for (int i = 0; i < n; i++) step();
  endtask

  initial begin
    #(8 * 150000);
    fails++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    void'($urandom(32'h1DC0_FFEE));
    rst = 1'b1; wr_en = 1'b0; wr_data = 8'h00; tx_en = 1'b0;
    @(negedge clk);
    run(3);
    rst = 1'b0;
    // R1: reset state observed before any edge out of reset
    chk("R1", 32'(rd_data), 32'h03);
    chk("R1", 32'(carrier_out), 0);
    chk("R1", 32'(timer_tick), 0);
    chk("R1", 32'(dp_hi), 0);
    run(40);                          // R9: tx_en low, R6 ticks at 16
    tx_en = 1'b1;
    run(50);                          // R11 default setting
    write(8'hFF);                     // R2, R7: all-ones, off and halved
    run(60);
    write(8'hC0);                     // R10: bit 3 falls, R3 sel 00
    run(20);
    write(8'h01); run(40);            // R3 sel 01
    write(8'h02); run(60);            // R3 sel 10
    write(8'h0B); run(100);           // R5, R11 halved 1/3
    write(8'h09); run(7);             // R8 mid-phase restart
    write(8'h09); run(70);
    write(8'h08); run(10);            // R5 fastest halved
    write(8'h24); run(30);            // R4 with tx_en
    tx_en = 1'b0; run(10);            // R9
    tx_en = 1'b1;
    for (int i = 0; i < 6000; i++) begin
      wr_en   = ($urandom % 40) == 0;
      wr_data = 8'($urandom);
      if (($urandom % 60) == 0) tx_en = ~tx_en;
      step();
    end
    wr_en = 1'b0;
    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

endmodule